// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block scans a grid of key switches. It pulls one row line low at a time and reads the column lines, which sit high through pull-ups. A key that is held down on the active row pulls its column low. The columns pass through a two-stage synchronizer. After the row has been driven for a fixed number of settle cycles, the block samples the columns for that row. Each key has its own saturating integration counter, which compares the fresh sample against the key's last accepted state. A change is accepted only when it has been seen on several consecutive scans. Each accepted change becomes a record in an event queue. The record holds the row index, the column index and a pressed or released flag.

The host reads records through a valid/ready handshake. When the queue is full, the block does not accept a matured change: the accepted state stays as it was and the counter stays saturated. The same change is then offered again on the next scan of that row, so no event is lost. The matrix is assumed to have a diode per switch, so the block does no ghost filtering. The number of rows, columns, cycles per row, settle cycles, debounce samples and queue entries are all parameters.

Top module: `kbd_matrix_scan`

## Requirements
- R1: During and just after reset, only row line 0 is low, every other row line is high, and no event is offered.
- R2: Exactly one row line is low at any time. The active row advances in the order 0, 1, …, ROWS-1 and then wraps to 0, and each row stays active for ROW_DWELL clock cycles.
- R3: A column input that reads low while a row is active means the key at that row and column is pressed. The event flag is 1 for a press and 0 for a release.
- R4: The row field of an event is the index of the row line that was low, and the column field is the bit position c of the column input col_in_n[c].
- R5: A change is accepted only after DB_COUNT consecutive scans of its row show the key in the new state. One scan that agrees with the accepted state restarts the count, so a contact shorter than that window produces no event. With the default parameters, an event appears between 129 and 200 cycles after a clean press.
- R6: Each accepted change produces exactly one event, and a key held steady produces no further events.
- R7: When several keys in one row mature in the same scan, the lowest column is queued first. Each later scan of that row queues the next one.
- R8: The event queue holds FIFO_DEPTH (8) records. While it is full, a matured change is not accepted, and it is offered again on later scans, so no event is lost or duplicated.
- R9: evt_valid stays high, and the fields stay unchanged, until evt_ready is seen high at a clock edge. Each such handshake removes exactly one record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_drv_n | output | ROWS | Row strobes; the active row is low |
| col_in_n | input | COLS | Raw column lines, high when idle |
| evt_valid | output | 1 | A record is at the head of the queue |
| evt_ready | input | 1 | Consumer takes the head record |
| evt_row | output | idx_w(ROWS) | Row index of the record |
| evt_col | output | idx_w(COLS) | Column index of the record |
| evt_pressed | output | 1 | 1 = press, 0 = release |

## Verification
The bench drives a behavioural matrix and goes after five corner cases.

- **Debounce window.** It checks the earliest and latest cycle at which a press may emerge. A scanner with an off-by-one integration count would release the event a whole scan early.
- **Short and interrupted contacts.** A design whose counter does not restart on one agreeing sample would add up the two halves of the interrupted contact into a false press.
- **Same-row collision.** Two keys of one row mature together. A wrong priority order, or a second record dropped in that scan, shows up here.
- **Queue full.** Ten changes are offered into an eight-record queue with the reader stalled. A design that updated its accepted state without queuing the record would lose the overflow.
- **Stalled head.** The bench checks that the head record stays put while the reader is stalled.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

   // index width that never collapses to zero bits
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   localparam int KBD_MIN_SYNC = 2;

endpackage

// File: rtl/kbd_row_strobe.sv
module kbd_row_strobe
   import kbd_scan_pkg::*;
#(
   parameter int ROWS   = 4,
   parameter int DWELL  = 16,
   parameter int SETTLE = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   output logic [ROWS-1:0]          row_n_o,
   output logic [idx_w(ROWS)-1:0]   row_idx_o,
   output logic                     cap_o
);
   localparam int RW = idx_w(ROWS);
   localparam int DW = idx_w(DWELL);

   logic [RW-1:0] row_q;
   logic [DW-1:0] dwell_q;
   logic          last_dwell;
   logic          last_row;

   assign last_dwell = (dwell_q == DW'(DWELL - 1));
   assign last_row   = (row_q == RW'(ROWS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q   <= '0;
         dwell_q <= '0;
      end else if (last_dwell) begin
         dwell_q <= '0;
         row_q   <= last_row ? '0 : row_q + 1'b1;
      end else begin
         dwell_q <= dwell_q + 1'b1;
      end
   end

   // decoder: one strobe per row, active low
   for (genvar r = 0; r < ROWS; r++) begin : g_dec
      assign row_n_o[r] = (row_q != RW'(r));
   end

   assign row_idx_o = row_q;
   assign cap_o     = (dwell_q == DW'(SETTLE));

   a_r2_one_row_low : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(row_n_o) == ROWS - 1);

   a_r2_row_step : assert property (@(posedge clk) disable iff (!rst_n)
      (row_q != $past(row_q)) |-> ($past(dwell_q) == DW'(DWELL - 1)));

endmodule

// File: rtl/kbd_col_sync.sv
module kbd_col_sync #(
   parameter int COLS   = 4,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [COLS-1:0] col_n_i,
   output logic [COLS-1:0] col_n_o
);
   logic [COLS-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '1;
            else        chain_q[s] <= col_n_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '1;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign col_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce
   import kbd_scan_pkg::*;
#(
   parameter int ROWS     = 4,
   parameter int COLS     = 4,
   parameter int DB_COUNT = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_i,
   input  logic [idx_w(ROWS)-1:0]  row_i,
   input  logic [COLS-1:0]         col_n_i,
   input  logic                    full_i,
   output logic                    push_o,
   output logic [idx_w(ROWS)-1:0]  evt_row_o,
   output logic [idx_w(COLS)-1:0]  evt_col_o,
   output logic                    evt_press_o
);
   localparam int RW   = idx_w(ROWS);
   localparam int CLW  = idx_w(COLS);
   localparam int KEYS = ROWS * COLS;
   localparam int KW   = idx_w(KEYS);
   localparam int CNTW = idx_w(DB_COUNT + 1);

   logic [COLS-1:0] smp;
   logic [KEYS-1:0] stable_q;
   logic [KEYS-1:0] cand;
   logic [KEYS-1:0] win;
   logic [KW-1:0]   win_idx;
   logic            any_cand;

   assign smp = ~col_n_i;   // 1 = pressed

   for (genvar k = 0; k < KEYS; k++) begin : g_key
      localparam int KR = k / COLS;
      localparam int KC = k % COLS;
      logic            st_q;
      logic [CNTW-1:0] cnt_q;
      logic            sel;
      logic            diff;

      assign sel     = cap_i && (row_i == RW'(KR));
      assign diff    = smp[KC] ^ st_q;
      assign cand[k] = sel && diff && (cnt_q >= CNTW'(DB_COUNT - 1));
      assign stable_q[k] = st_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= 1'b0;
            cnt_q <= '0;
         end else if (sel) begin
            if (win[k] && push_o) begin
               st_q  <= ~st_q;
               cnt_q <= '0;
            end else if (diff) begin
               if (cnt_q != CNTW'(DB_COUNT)) cnt_q <= cnt_q + 1'b1;
            end else begin
               cnt_q <= '0;
            end
         end
      end
   end

   // lowest index wins; only one row is ever sampled, so that is the lowest column
   always_comb begin
      any_cand = 1'b0;
      win_idx  = '0;
      for (int k = KEYS - 1; k >= 0; k--) begin
         if (cand[k]) begin
            any_cand = 1'b1;
            win_idx  = KW'(k);
         end
      end
   end

   assign win         = any_cand ? (KEYS'(1) << win_idx) : '0;
   assign push_o      = any_cand && !full_i;
   assign evt_row_o   = RW'(int'(win_idx) / COLS);
   assign evt_col_o   = CLW'(int'(win_idx) % COLS);
   assign evt_press_o = ~stable_q[win_idx];

   a_r5_commit_on_capture : assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(stable_q));

   a_r6_single_commit : assert property (@(posedge clk) disable iff (!rst_n)
      $countones(stable_q ^ $past(stable_q)) <= 1);

   a_r8_hold_when_full : assert property (@(posedge clk) disable iff (!rst_n)
      full_i |=> $stable(stable_q));

endmodule

// File: rtl/kbd_evt_fifo.sv
module kbd_evt_fifo
   import kbd_scan_pkg::*;
#(
   parameter int W     = 5,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] din_i,
   input  logic         pop_i,
   output logic [W-1:0] dout_o,
   output logic         valid_o,
   output logic         full_o
);
   localparam int PW   = idx_w(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);

   logic [W-1:0]    mem [DEPTH];
   logic [PW-1:0]   wr_q, rd_q, wr_nxt, rd_nxt;
   logic [CNTW-1:0] cnt_q;
   logic            do_push, do_pop;

   assign full_o  = (cnt_q == CNTW'(DEPTH));
   assign valid_o = (cnt_q != '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && valid_o;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_q + 1'b1;
      assign rd_nxt = rd_q + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      assign rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_nxt;
         if (do_pop)  rd_q <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout_o = mem[rd_q];

   a_r8_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);

   a_r9_head_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !pop_i) |=> (valid_o && $stable(dout_o)));

endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan
   import kbd_scan_pkg::*;
#(
   parameter int ROWS        = 4,
   parameter int COLS        = 4,
   parameter int ROW_DWELL   = 16,
   parameter int SETTLE_CYC  = 4,
   parameter int DB_COUNT    = 3,
   parameter int FIFO_DEPTH  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   output logic [ROWS-1:0]         row_drv_n,
   input  logic [COLS-1:0]         col_in_n,
   output logic                    evt_valid,
   input  logic                    evt_ready,
   output logic [idx_w(ROWS)-1:0]  evt_row,
   output logic [idx_w(COLS)-1:0]  evt_col,
   output logic                    evt_pressed
);
   localparam int RW  = idx_w(ROWS);
   localparam int CLW = idx_w(COLS);
   localparam int EW  = RW + CLW + 1;

   if (ROWS < 2 || COLS < 2) begin : g_bad_dim
      $error("matrix needs at least two rows and two columns");
   end
   if (SYNC_STAGES < KBD_MIN_SYNC) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end
   if (SETTLE_CYC < SYNC_STAGES || SETTLE_CYC >= ROW_DWELL) begin : g_bad_settle
      $error("settle time must cover the synchronizer and end inside the row dwell");
   end
   if (DB_COUNT < 1 || FIFO_DEPTH < 2) begin : g_bad_depth
      $error("debounce count and queue depth out of range");
   end

   logic [RW-1:0]   row_idx;
   logic            cap;
   logic [COLS-1:0] col_sync_n;
   logic            push, full;
   logic [RW-1:0]   d_row;
   logic [CLW-1:0]  d_col;
   logic            d_press;
   logic [EW-1:0]   head;

   kbd_row_strobe #(.ROWS(ROWS), .DWELL(ROW_DWELL), .SETTLE(SETTLE_CYC)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .row_n_o   (row_drv_n),
      .row_idx_o (row_idx),
      .cap_o     (cap)
   );

   kbd_col_sync #(.COLS(COLS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .col_n_i (col_in_n),
      .col_n_o (col_sync_n)
   );

   kbd_debounce #(.ROWS(ROWS), .COLS(COLS), .DB_COUNT(DB_COUNT)) u_deb (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_i       (cap),
      .row_i       (row_idx),
      .col_n_i     (col_sync_n),
      .full_i      (full),
      .push_o      (push),
      .evt_row_o   (d_row),
      .evt_col_o   (d_col),
      .evt_press_o (d_press)
   );

   kbd_evt_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .din_i   ({d_row, d_col, d_press}),
      .pop_i   (evt_ready),
      .dout_o  (head),
      .valid_o (evt_valid),
      .full_o  (full)
   );

   assign evt_row     = head[EW-1 -: RW];
   assign evt_col     = head[CLW:1];
   assign evt_pressed = head[0];

endmodule

// File: tb/sim_kbd_matrix_scan.sv
`timescale 1ns/1ps
module sim_kbd_matrix_scan;
   localparam int PERIOD = 64;   // 4 rows x 16 cycles

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] row_n;
   logic [3:0] col_n;
   logic       evt_valid;
   logic       evt_ready = 1'b0;
   logic [1:0] evt_row, evt_col;
   logic       evt_pressed;
   logic [15:0] keys = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   // behavioural matrix with per-switch diodes
   always_comb begin
      col_n = '1;
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            if (keys[r*4+c] && !row_n[r]) col_n[c] = 1'b0;
   end

   kbd_matrix_scan u0 (
      .clk(clk), .rst_n(rst_n), .row_drv_n(row_n), .col_in_n(col_n),
      .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_row(evt_row),
      .evt_col(evt_col), .evt_pressed(evt_pressed)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic get_evt(input int tmo, output bit ok, output int r, output int c,
                          output int p, output int lat);
      ok = 0; r = -1; c = -1; p = -1; lat = tmo;
      for (int i = 0; i < tmo; i++) begin
         @(negedge clk);
         if (evt_valid) begin
            r = evt_row; c = evt_col; p = evt_pressed; lat = i + 1; ok = 1;
            evt_ready = 1'b1;
            @(negedge clk);
            evt_ready = 1'b0;
            break;
         end
      end
   endtask

   task automatic expect_evt(input string req, input int er, input int ec, input int ep);
      bit ok; int r, c, p, lat;
      get_evt(400, ok, r, c, p, lat);
      chk(ok, req, "event arrives", ok, 1);
      chk(r == er, req, "row field", r, er);
      chk(c == ec, req, "col field", c, ec);
      chk(p == ep, req, "pressed flag", p, ep);
   endtask

   task automatic expect_quiet(input string req, input int cycles);
      bit seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (evt_valid) seen = 1;
      end
      chk(!seen, req, "no event", seen, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(row_n == 4'b1110, "R1", "row strobes in reset", row_n, 4'b1110);
      chk(!evt_valid, "R1", "valid in reset", evt_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(row_n == 4'b1110, "R1", "row strobes after reset", row_n, 4'b1110);
      chk(!evt_valid, "R1", "valid after reset", evt_valid, 0);
   endtask

   task automatic t_row_order;
      int cur, prev, len;
      prev = -1;
      // skip to a row boundary
      cur = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (row_n != 4'b1110) break;
      end
      for (int t = 0; t < 6; t++) begin
         cur = -1;
         for (int r = 0; r < 4; r++) if (!row_n[r]) cur = r;
         chk($countones(~row_n) == 1, "R2", "single low row", $countones(~row_n), 1);
         if (prev >= 0) chk(cur == (prev + 1) % 4, "R2", "row order", cur, (prev + 1) % 4);
         len = 0;
         begin
            logic [3:0] snap = row_n;
            while (row_n == snap && len < 100) begin
               len++;
               @(negedge clk);
            end
         end
         chk(len == 16, "R2", "row dwell", len, 16);
         prev = cur;
      end
   endtask

   task automatic t_press_release;
      bit ok; int r, c, p, lat;
      // key at row 1, col 2
      keys[6] = 1'b1;
      get_evt(400, ok, r, c, p, lat);
      chk(ok && r == 1 && c == 2, "R4", "press position", r*4+c, 6);
      chk(p == 1, "R3", "press flag", p, 1);
      chk(lat >= 129 && lat <= 200, "R5", "press latency", lat, 160);
      expect_quiet("R6", 300);
      keys[6] = 1'b0;
      expect_evt("R3", 1, 2, 0);
      keys[15] = 1'b1;
      expect_evt("R4", 3, 3, 1);
      keys[15] = 1'b0;
      expect_evt("R4", 3, 3, 0);
      keys[0] = 1'b1;
      expect_evt("R4", 0, 0, 1);
      keys[0] = 1'b0;
      expect_evt("R4", 0, 0, 0);
   endtask

   task automatic t_glitch;
      keys[9] = 1'b1;
      repeat (30) @(negedge clk);
      keys[9] = 1'b0;
      expect_quiet("R5", 300);
      // interrupted contact: two short presses split by a release scan
      keys[9] = 1'b1;
      repeat (100) @(negedge clk);
      keys[9] = 1'b0;
      repeat (70) @(negedge clk);
      keys[9] = 1'b1;
      repeat (100) @(negedge clk);
      keys[9] = 1'b0;
      expect_quiet("R5", 300);
   endtask

   task automatic t_same_row;
      keys[11] = 1'b1;
      keys[8]  = 1'b1;
      expect_evt("R7", 2, 0, 1);
      expect_evt("R7", 2, 3, 1);
      keys[11] = 1'b0;
      keys[8]  = 1'b0;
      expect_evt("R7", 2, 0, 0);
      expect_evt("R7", 2, 3, 0);
   endtask

   task automatic t_fifo_full;
      logic [15:0] mask = 16'h3775;
      logic [15:0] seen;
      bit ok; int r, c, p, lat;
      int hr, hc, hp;
      bit held;
      for (int pass = 0; pass < 2; pass++) begin
         keys = (pass == 0) ? mask : 16'h0000;
         repeat (700) @(negedge clk);
         chk(evt_valid, "R9", "valid while stalled", evt_valid, 1);
         hr = evt_row; hc = evt_col; hp = evt_pressed;
         held = 1;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!evt_valid || evt_row != hr || evt_col != hc || evt_pressed != hp) held = 0;
         end
         chk(held, "R9", "head stable while stalled", held, 1);
         seen = '0;
         for (int e = 0; e < 10; e++) begin
            get_evt(300, ok, r, c, p, lat);
            chk(ok, "R8", "queued event delivered", e, 10);
            if (ok) begin
               chk(mask[r*4+c] && !seen[r*4+c], "R8", "event key unique", r*4+c, -1);
               chk(p == (pass == 0 ? 1 : 0), "R8", "event flag", p, pass == 0 ? 1 : 0);
               seen[r*4+c] = 1'b1;
            end
         end
         chk(seen == mask, "R8", "all changes delivered", seen, mask);
         expect_quiet("R8", 300);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_row_order();
      t_press_release();
      t_glitch();
      t_same_row();
      t_fifo_full();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule